// File: doc/BRIEF.md
# Serial link transmit framing controller

This block sequences the digital side of a high-speed serial transmitter. It decides which 40-bit word an external serializer takes next and when it takes it. After a warm-up request it sends a repeating training word so that the far-end receiver can recover the clock. When a link request arrives and upstream data is waiting, it sends a start flit. It then forwards already-encoded payload words from an upstream FIFO until that FIFO runs dry. At that point it closes the frame with a stop flit and goes back to rest.

The controller runs on a clock that is one quarter of the serializer clock. The serializer shifts 40 bits out on both edges of its own clock, so one word lasts 20 fast-clock cycles, which is 5 controller cycles. Every word after the first is therefore loaded exactly 5 controller cycles after the one before it. The word bus, the load strobe and the FIFO pop are combinational decisions, made on the state and on the inputs of the current cycle. The serializer and the FIFO both act on the clock edge that ends a strobed cycle.

Top module: `lnk_tx_framer`

## Requirements
- R1: While reset is held and the inputs are low, and on the first cycle after release, no word is loaded, the FIFO is not popped and the word bus is all zeros.
- R2: In the rest state, warm-up enable alone (with no start condition) loads the training word in that same cycle and enters warm-up. Warm-up reloads the training word every 5 cycles while warm-up enable or link enable stays high.
- R3: Bit i of the training word equals i mod 2, which gives 40'hAAAAAAAAAA for 40 bits.
- R4: A start flit is loaded only in the rest state, or at a word boundary in warm-up, and only when link enable and upstream valid are both high. This condition takes priority over training. The start flit repeats the byte 8'hDF in every byte lane, giving 40'hDFDFDFDFDF.
- R5: Five cycles after a start flit, with no further command, a payload word is loaded if upstream valid is high.
- R6: During payload, words are loaded exactly every 5 cycles. The word on the bus equals the FIFO data presented in that cycle.
- R7: The FIFO is popped exactly in the cycles that load a payload word. It is never popped with a flit or with a training word.
- R8: At a word boundary after a start flit or a payload word, low upstream valid loads the stop flit, 40'hBFBFBFBFBF, without a pop. Both enables are ignored from the start flit up to the stop flit.
- R9: Five cycles after the stop flit the controller goes back to rest without loading. The earliest next load comes one cycle later.
- R10: At a warm-up word boundary with both enables low, the controller goes back to rest with no load. With link enable high and valid low, training continues.
- R11: Between word boundaries no word is loaded, no pop occurs and the word bus is all zeros. In rest, with no enable condition met, the same holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (serializer clock divided by four) |
| rst_n | input | 1 | Active-low synchronous reset |
| warm_en_i | input | 1 | Warm-up (training) enable |
| comm_en_i | input | 1 | Link (data transfer) enable |
| fifo_valid_i | input | 1 | Upstream FIFO has an encoded word |
| fifo_data_i | input | 40 | Upstream encoded payload word |
| fifo_pop_o | output | 1 | Consume the presented FIFO word at this clock edge |
| ser_word_o | output | 40 | Word presented to the serializer |
| ser_load_o | output | 1 | Serializer takes ser_word_o at this clock edge |

## Verification
The assertions check a number of rules on every cycle:
- a pop always comes with a load of exactly the presented FIFO word;
- payload loads keep the 5-cycle spacing;
- a start or stop decision at a boundary always produces the matching flit code;
- no word moves between boundaries;
- each training load has the alternating bit structure.

Other behaviours show only across the bench's scenarios:
- the full order of phases within a frame;
- the start condition taking priority over training;
- the enables having no effect in the middle of a frame;
- the one-cycle rest gap after a stop flit;
- the effect of a mid-stream valid drop.

// File: rtl/lnk_txfrm_pkg.sv
package lnk_txfrm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WARM  = 3'd1,
    ST_START = 3'd2,
    ST_DATA  = 3'd3,
    ST_STOP  = 3'd4
  } lnk_st_e;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_TRAIN = 3'd1,
    SEL_START = 3'd2,
    SEL_PAY   = 3'd3,
    SEL_STOP  = 3'd4
  } lnk_sel_e;

  typedef struct packed {
    lnk_st_e  ns;
    lnk_sel_e sel;
  } lnk_step_t;

  // One decision of the framing sequence: next phase and which word to load.
  function automatic lnk_step_t plan_step(input lnk_st_e st, input logic bnd,
                                          input logic warm, input logic comm,
                                          input logic vld);
    lnk_step_t s;
    s.ns  = st;
    s.sel = SEL_NONE;
    if (bnd) begin
      case (st)
        ST_IDLE: begin
          if (comm && vld) begin
            s.ns = ST_START; s.sel = SEL_START;
          end else if (warm) begin
            s.ns = ST_WARM;  s.sel = SEL_TRAIN;
          end else begin
            s.ns = ST_IDLE;
          end
        end
        ST_WARM: begin
          if (comm && vld) begin
            s.ns = ST_START; s.sel = SEL_START;
          end else if (warm || comm) begin
            s.ns = ST_WARM;  s.sel = SEL_TRAIN;
          end else begin
            s.ns = ST_IDLE;
          end
        end
        ST_START, ST_DATA: begin
          if (vld) begin
            s.ns = ST_DATA; s.sel = SEL_PAY;
          end else begin
            s.ns = ST_STOP; s.sel = SEL_STOP;
          end
        end
        ST_STOP: s.ns = ST_IDLE;
        default: s.ns = ST_IDLE;
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/lnk_word_timer.sv
module lnk_word_timer #(
  parameter int LOAD_PERIOD = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic load_i,
  output logic bnd_o
);
  localparam int CW = (LOAD_PERIOD > 1) ? $clog2(LOAD_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOAD_PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load_i)     cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  // In rest every cycle may decide; otherwise only the last cycle of a word.
  assign bnd_o = !active_i || (cnt == LAST);
endmodule

// File: rtl/lnk_train_gen.sv
module lnk_train_gen #(
  parameter int WORD_W = 40
) (
  output logic [WORD_W-1:0] pattern_o
);
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign pattern_o[i] = 1'(i % 2);
  end
endmodule

// File: rtl/lnk_word_mux.sv
module lnk_word_mux
  import lnk_txfrm_pkg::*;
#(
  parameter int          WORD_W     = 40,
  parameter logic [7:0]  START_CODE = 8'hDF,
  parameter logic [7:0]  STOP_CODE  = 8'hBF
) (
  input  lnk_sel_e          sel_i,
  input  logic [WORD_W-1:0] train_i,
  input  logic [WORD_W-1:0] pay_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] start_flit;
  logic [WORD_W-1:0] stop_flit;

  for (genvar i = 0; i < WORD_W; i++) begin : g_flit
    assign start_flit[i] = START_CODE[i % 8];
    assign stop_flit[i]  = STOP_CODE[i % 8];
  end

  always_comb begin
    case (sel_i)
      SEL_TRAIN: word_o = train_i;
      SEL_START: word_o = start_flit;
      SEL_PAY:   word_o = pay_i;
      SEL_STOP:  word_o = stop_flit;
      default:   word_o = '0;
    endcase
  end
endmodule

// File: rtl/lnk_frame_fsm.sv
module lnk_frame_fsm
  import lnk_txfrm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bnd_i,
  input  logic     warm_i,
  input  logic     comm_i,
  input  logic     vld_i,
  output lnk_st_e  st_o,
  output lnk_sel_e sel_o,
  output logic     load_o,
  output logic     pop_o
);
  lnk_st_e   st;
  lnk_step_t step;

  always_comb step = plan_step(st, bnd_i, warm_i, comm_i, vld_i);

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= step.ns;
  end

  assign st_o   = st;
  assign sel_o  = step.sel;
  assign load_o = (step.sel != SEL_NONE);
  assign pop_o  = (step.sel == SEL_PAY);
endmodule

// File: rtl/lnk_tx_framer.sv
module lnk_tx_framer
  import lnk_txfrm_pkg::*;
#(
  parameter int         WORD_W      = 40,
  parameter int         LOAD_PERIOD = 5,
  parameter logic [7:0] START_CODE  = 8'hDF,
  parameter logic [7:0] STOP_CODE   = 8'hBF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_en_i,
  input  logic              comm_en_i,
  input  logic              fifo_valid_i,
  input  logic [WORD_W-1:0] fifo_data_i,
  output logic              fifo_pop_o,
  output logic [WORD_W-1:0] ser_word_o,
  output logic              ser_load_o
);
  // Named internal events, used by the bound checker.
  lnk_st_e           st;
  lnk_sel_e          sel;
  logic              word_bnd;
  logic              load;
  logic              pop;
  logic [WORD_W-1:0] train_word;

  lnk_word_timer #(.LOAD_PERIOD(LOAD_PERIOD)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (st != ST_IDLE),
    .load_i   (load),
    .bnd_o    (word_bnd)
  );

  lnk_frame_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .bnd_i  (word_bnd),
    .warm_i (warm_en_i),
    .comm_i (comm_en_i),
    .vld_i  (fifo_valid_i),
    .st_o   (st),
    .sel_o  (sel),
    .load_o (load),
    .pop_o  (pop)
  );

  lnk_train_gen #(.WORD_W(WORD_W)) u_train (
    .pattern_o (train_word)
  );

  lnk_word_mux #(
    .WORD_W     (WORD_W),
    .START_CODE (START_CODE),
    .STOP_CODE  (STOP_CODE)
  ) u_mux (
    .sel_i   (sel),
    .train_i (train_word),
    .pay_i   (fifo_data_i),
    .word_o  (ser_word_o)
  );

  assign ser_load_o = load;
  assign fifo_pop_o = pop;
endmodule

// File: rtl/lnk_tx_framer_chk.sv
module lnk_tx_framer_chk
  import lnk_txfrm_pkg::*;
#(
  parameter int         WORD_W      = 40,
  parameter int         LOAD_PERIOD = 5,
  parameter logic [7:0] START_CODE  = 8'hDF,
  parameter logic [7:0] STOP_CODE   = 8'hBF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              warm_en_i,
  input logic              comm_en_i,
  input logic              fifo_valid_i,
  input logic [WORD_W-1:0] fifo_data_i,
  input logic              fifo_pop_o,
  input logic [WORD_W-1:0] ser_word_o,
  input logic              ser_load_o,
  input logic [2:0]        st,
  input logic              word_bnd
);
  logic [15:0] since;
  logic        rest_or_warm;
  logic [WORD_W-1:0] alt_mix;

  always_ff @(posedge clk) begin
    if (!rst_n)             since <= '0;
    else if (ser_load_o)    since <= 16'd1;
    else if (since != '1)   since <= since + 1'b1;
  end

  assign rest_or_warm = (st == ST_IDLE) || (st == ST_WARM);
  assign alt_mix      = ser_word_o ^ (ser_word_o >> 1);

  // R2: warm-up enable in rest loads something other than payload
  a_r2_warm_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && warm_en_i && !(comm_en_i && fifo_valid_i)) |-> (ser_load_o && !fifo_pop_o));

  // R3: training loads have alternating bits, bit 0 low
  a_r3_train_alt: assert property (@(posedge clk) disable iff (!rst_n)
    (rest_or_warm && word_bnd && ser_load_o && !(comm_en_i && fifo_valid_i))
      |-> (!ser_word_o[0] && (alt_mix[WORD_W-2:0] == '1)));

  // R4: start condition loads the start flit
  a_r4_start_flit: assert property (@(posedge clk) disable iff (!rst_n)
    (rest_or_warm && word_bnd && comm_en_i && fifo_valid_i)
      |-> (ser_load_o && !fifo_pop_o && ser_word_o[7:0] == START_CODE));

  // R5: payload follows the start flit automatically
  a_r5_auto_data: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && word_bnd && fifo_valid_i) |-> fifo_pop_o);

  // R6: payload loads keep the fixed spacing
  a_r6_cadence: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && ser_load_o) |-> (since == 16'(LOAD_PERIOD)));

  // R7: a pop carries exactly the presented FIFO word
  a_r7_pop_word: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |-> (ser_load_o && fifo_valid_i && ser_word_o == fifo_data_i));

  // R8: valid low at a frame boundary closes with the stop flit
  a_r8_stop_flit: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_START || st == ST_DATA) && word_bnd && !fifo_valid_i)
      |-> (ser_load_o && !fifo_pop_o && ser_word_o[7:0] == STOP_CODE));

  // R9: stop phase ends in rest without a load
  a_r9_stop_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP && word_bnd) |-> (!ser_load_o ##1 st == ST_IDLE));

  // R10: both enables low ends warm-up silently
  a_r10_warm_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WARM && word_bnd && !warm_en_i && !comm_en_i) |=> (st == ST_IDLE));

  // R11: no traffic between word boundaries
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_bnd) |-> (!ser_load_o && !fifo_pop_o && ser_word_o == '0));
endmodule

bind lnk_tx_framer lnk_tx_framer_chk #(
  .WORD_W      (WORD_W),
  .LOAD_PERIOD (LOAD_PERIOD),
  .START_CODE  (START_CODE),
  .STOP_CODE   (STOP_CODE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .warm_en_i    (warm_en_i),
  .comm_en_i    (comm_en_i),
  .fifo_valid_i (fifo_valid_i),
  .fifo_data_i  (fifo_data_i),
  .fifo_pop_o   (fifo_pop_o),
  .ser_word_o   (ser_word_o),
  .ser_load_o   (ser_load_o),
  .st           (st),
  .word_bnd     (word_bnd)
);

// File: tb/lnk_tx_framer_tb.sv
module lnk_tx_framer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 40;
  localparam int LP = 5;
  localparam int M_IDLE = 0, M_WARM = 1, M_START = 2, M_DATA = 3, M_STOP = 4;
  localparam int K_NONE = 0, K_TRAIN = 1, K_START = 2, K_PAY = 3, K_STOP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic warm = 1'b0, comm = 1'b0, valid = 1'b0;
  logic [WW-1:0] fdata = '0;
  logic          pop, load;
  logic [WW-1:0] word;

  int n_checks = 0;
  int n_fail = 0;
  int m_mode = M_IDLE;
  int m_age = 0;
  int seq = 0;
  int last_kind = K_NONE;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lnk_tx_framer u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .warm_en_i    (warm),
    .comm_en_i    (comm),
    .fifo_valid_i (valid),
    .fifo_data_i  (fdata),
    .fifo_pop_o   (pop),
    .ser_word_o   (word),
    .ser_load_o   (load)
  );

  function automatic logic [WW-1:0] flit_of(input logic [7:0] code);
    logic [WW-1:0] r;
    for (int i = 0; i < WW; i++) r[i] = code[i % 8];
    return r;
  endfunction

  function automatic logic [WW-1:0] train_of();
    logic [WW-1:0] r;
    for (int i = 0; i < WW; i++) r[i] = ((i & 1) == 1);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One controller cycle: drive inputs, compare combinational outputs, advance model.
  task automatic cycle(input logic w, input logic c, input logic v);
    int kind;
    int nmode;
    bit due;
    string tag;
    logic [WW-1:0] ew;
    @(negedge clk);
    warm = w; comm = c; valid = v;
    fdata = {8'h5A, 32'(seq)};
    #1;
    due = (m_mode == M_IDLE) || (m_age >= LP);
    kind = K_NONE;
    nmode = m_mode;
    if (due) begin
      if (m_mode == M_IDLE || m_mode == M_WARM) begin
        if (c && v) begin kind = K_START; nmode = M_START; end
        else if (w || (m_mode == M_WARM && c)) begin kind = K_TRAIN; nmode = M_WARM; end
        else nmode = M_IDLE;
      end else if (m_mode == M_START || m_mode == M_DATA) begin
        if (v) begin kind = K_PAY; nmode = M_DATA; end
        else begin kind = K_STOP; nmode = M_STOP; end
      end else nmode = M_IDLE;
    end
    case (kind)
      K_TRAIN: begin ew = train_of();       tag = "R2/R3"; end
      K_START: begin ew = flit_of(8'hDF);   tag = "R4"; end
      K_PAY:   begin ew = fdata;            tag = (m_mode == M_START) ? "R5" : "R6"; end
      K_STOP:  begin ew = flit_of(8'hBF);   tag = "R8"; end
      default: begin
        ew = '0;
        if (m_mode == M_STOP && due)      tag = "R9";
        else if (m_mode == M_WARM && due) tag = "R10";
        else                              tag = "R11";
      end
    endcase
    chk(load === (kind != K_NONE), tag, "load", WW'(load), WW'(kind != K_NONE));
    chk(word === ew, tag, "word", word, ew);
    chk(pop === (kind == K_PAY), "R7", "pop", WW'(pop), WW'(kind == K_PAY));
    if (kind == K_PAY) seq++;
    if (kind != K_NONE) m_age = 1;
    else if (m_age < 1000) m_age++;
    m_mode = nmode;
    last_kind = kind;
  endtask

  task automatic run_frame(input int wdur, input int nwords, input int gapat, input bit noisy);
    int avail;
    avail = nwords;
    for (int i = 0; i < wdur; i++) cycle(1'b1, 1'b0, 1'b0);
    for (int j = 0; j < 6 * (nwords + 3); j++) begin
      // R8: enable toggling mid-frame must not change the sequence
      cycle(noisy ? 1'((j % 7) == 3) : 1'b0,
            noisy ? 1'((j % 3) != 1) : 1'b1,
            1'((avail > 0) && (j != gapat)));
      if (last_kind == K_PAY) avail--;
      if (avail == 0 && !noisy && m_mode == M_IDLE) comm = 1'b0;
    end
    for (int k = 0; k < 8; k++) cycle(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    #1;
    chk(load === 1'b0, "R1", "load in reset", WW'(load), '0);
    chk(pop === 1'b0, "R1", "pop in reset", WW'(pop), '0);
    chk(word === '0, "R1", "word in reset", word, '0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(load === 1'b0 && pop === 1'b0 && word === '0, "R1", "after release",
        {load, pop}, '0);
    for (int k = 0; k < 4; k++) cycle(1'b0, 1'b0, 1'b0);

    // R10: link enable without data holds training; both low ends it
    for (int k = 0; k < 12; k++) cycle(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 12; k++) cycle(1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 8; k++) cycle(1'b0, 1'b0, 1'b0);

    // Sweep of warm-up lengths, frame lengths and a mid-stream valid drop.
    for (int wd = 0; wd < 6; wd++)
      for (int nw = 0; nw < 6; nw++)
        for (int g = 0; g < 2; g++)
          run_frame(wd, nw, g ? 7 : -1, 1'b0);

    // Frames with enables toggling after the start flit.
    for (int nw = 1; nw < 5; nw++) run_frame(2, nw, -1, 1'b1);

    // Pseudo-random stimulus against the model.
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cycle(1'(lfsr[3:2] == 2'b00), 1'(lfsr[7:5] != 3'b000), 1'(lfsr[11:9] != 3'b000));
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule